// File: doc/BRIEF.md
# Byte-Lane Load/Store Bus Master

This block sits between a 32-bit processor's execute stage and a simple memory bus with a single master. Each core request is an instruction fetch, or a data load or store of byte, halfword or word size at a byte address. An accepted request becomes exactly one bus cycle. The block drives a word address, a bus enable, a write strobe, a four-lane byte mask and a fetch/data flag. It holds all of them steady until the peripheral answers with ready.

On a store, the byte or halfword is copied onto every lane it could occupy, and the mask selects the live lanes. On a load, the addressed lanes are taken from the returned word and sign- or zero-extended to 32 bits. The result is handed back to the core with a one-clock done pulse. A halfword or word request whose address is not naturally aligned never reaches the bus. Instead, a one-clock misalignment error is raised. All outputs are registered, and reset is synchronous and active high.

Top module: `lsu_bus_master`

## Requirements
- R1: `bus_addr` carries the accepted request's byte address with bits 1 and 0 forced to 0. It is loaded on the accepting clock edge and held until the next accepted request.
- R2: A request is accepted on a rising edge where `req_valid` is 1, `bus_en` is 0 and the access is aligned. `bus_en` rises on that edge and stays high until the edge at which `bus_ready` is sampled 1. Address, mask, write strobe, fetch flag and store data do not change in between.
- R3: The edge that samples `bus_ready` high while `bus_en` is 1 clears `bus_en` and `bus_wr`. On that same edge, `done` goes high for exactly one clock and `rdata` is loaded with the load result.
- R4: `bus_wr` is 1 only during a store cycle. `bus_fetch` is 1 for an instruction fetch and 0 for a data load or store. A fetch is always a word read: `req_write`, `req_size` and `req_unsigned` are ignored for it.
- R5: Size encoding of `req_size` is 00 for byte, 01 for halfword, and 10 or 11 for word. Mask bit i enables data bits 8i+7..8i. A byte access uses the one-hot mask `1 << addr[1:0]`. A halfword access uses 0011 when addr[1] is 0 and 1100 when it is 1. A word access uses 1111.
- R6: `bus_mask` only ever shows 1111, 1100, 0011, 1000, 0100, 0010 or 0001. It is 1111 after reset.
- R7: Store data is placed on the bus as follows. A byte store drives `wdata[7:0]` on all four lanes. A halfword store drives `wdata[15:0]` on both halves. A word store drives `wdata` unchanged.
- R8: Load results are formed from the word returned by the bus. A byte load takes lane addr[1:0]. A halfword load takes bits 15..0 when addr[1] is 0 and 31..16 when it is 1. When `req_unsigned` is 0 the value is sign-extended, and when it is 1 it is zero-extended. Word loads and fetches pass the bus word through unchanged.
- R9: If a halfword request has addr[0] set, or a word request or fetch has either low address bit set, no bus cycle starts. Instead, `misalign_err` is 1 for the following clock.
- R10: While `rst` is sampled high, `bus_en`, `bus_wr`, `done` and `misalign_err` are 0. `bus_fetch`, `bus_addr`, `bus_dout` and `rdata` are 0, and `bus_mask` is 1111.
- R11: A request presented while `bus_en` is 1 is ignored and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents a request this cycle |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_write | input | 1 | Data request is a store |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock pulse when a bus cycle ends |
| rdata | output | 32 | Extended load result, valid with done |
| misalign_err | output | 1 | One-clock pulse for a rejected misaligned request |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_din | input | 32 | Read data from the bus |
| bus_dout | output | 32 | Write data to the bus |
| bus_en | output | 1 | High for the whole bus cycle |
| bus_ready | input | 1 | Peripheral ends the cycle |
| bus_wr | output | 1 | Write strobe |
| bus_mask | output | 4 | Byte-lane enables |
| bus_fetch | output | 1 | 1 for fetch, 0 for data cycle |

## Verification
The assertions assume that `bus_ready` matters only while `bus_en` is high, and that any value may appear on it at other times. They place no restriction on how long a peripheral may stall. The stimulus therefore drives `bus_ready` and `bus_din` freshly at random every cycle, including outside bus cycles and during reset. It also keeps offering requests of every kind and alignment while the block is busy. Because of this, the rules for ignored requests and stable outputs are exercised against a free-running input rather than a polite one.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;
endpackage

// File: rtl/lsu_lane_pack.sv
module lsu_lane_pack
  import lsu_pkg::*;
(
  input  size_e               size,
  input  logic [OFF_W-1:0]    off,
  input  logic [DATA_W-1:0]   wdata,
  output logic [LANES-1:0]    mask,
  output logic [DATA_W-1:0]   lane_data
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          mask[i] = (off == OFF_W'(i));
          lane_data[8*i +: 8] = wdata[7:0];
        end
        SZ_HALF: begin
          mask[i] = ((i / 2) == int'(off[OFF_W-1]));
          lane_data[8*i +: 8] = wdata[8*(i%2) +: 8];
        end
        default: begin
          mask[i] = 1'b1;
          lane_data[8*i +: 8] = wdata[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_extract.sv
module lsu_lane_extract
  import lsu_pkg::*;
(
  input  size_e               size,
  input  logic                unsgn,
  input  logic [OFF_W-1:0]    off,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   value
);
  logic [7:0]  lane [LANES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lane[i] = din[8*i +: 8];
  end

  assign sel_b = lane[off];
  assign sel_h = off[OFF_W-1] ? din[31:16] : din[15:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: value = {{(DATA_W-8){sel_b[7] & ~unsgn}}, sel_b};
      SZ_HALF: value = {{(DATA_W-16){sel_h[15] & ~unsgn}}, sel_h};
      default: value = din;
    endcase
  end
endmodule

// File: rtl/lsu_bus_master.sv
module lsu_bus_master
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_fetch,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                misalign_err,
  output logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_din,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_en,
  input  logic                bus_ready,
  output logic                bus_wr,
  output logic [LANES-1:0]    bus_mask,
  output logic                bus_fetch
);
  size_e               req_sz;
  logic                req_misal;
  logic [LANES-1:0]    pk_mask;
  logic [DATA_W-1:0]   pk_data;
  logic [DATA_W-1:0]   ext_val;

  size_e               sz_q;
  logic                uns_q;
  logic [OFF_W-1:0]    off_q;

  always_comb begin
    if (req_fetch || req_size[1]) req_sz = SZ_WORD;
    else if (req_size[0])         req_sz = SZ_HALF;
    else                          req_sz = SZ_BYTE;
    unique case (req_sz)
      SZ_HALF: req_misal = req_addr[0];
      SZ_WORD: req_misal = |req_addr[OFF_W-1:0];
      default: req_misal = 1'b0;
    endcase
  end

  lsu_lane_pack u_pack (
    .size      (req_sz),
    .off       (req_addr[OFF_W-1:0]),
    .wdata     (req_wdata),
    .mask      (pk_mask),
    .lane_data (pk_data)
  );

  lsu_lane_extract u_ext (
    .size  (sz_q),
    .unsgn (uns_q),
    .off   (off_q),
    .din   (bus_din),
    .value (ext_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_en       <= 1'b0;
      bus_wr       <= 1'b0;
      bus_fetch    <= 1'b0;
      bus_addr     <= '0;
      bus_dout     <= '0;
      bus_mask     <= '1;
      done         <= 1'b0;
      misalign_err <= 1'b0;
      rdata        <= '0;
      sz_q         <= SZ_WORD;
      uns_q        <= 1'b0;
      off_q        <= '0;
    end else begin
      done         <= 1'b0;
      misalign_err <= 1'b0;
      if (bus_en) begin
        if (bus_ready) begin
          bus_en <= 1'b0;
          bus_wr <= 1'b0;
          done   <= 1'b1;
          rdata  <= ext_val;
        end
      end else if (req_valid) begin
        if (req_misal) begin
          misalign_err <= 1'b1;
        end else begin
          bus_en    <= 1'b1;
          bus_wr    <= req_write & ~req_fetch;
          bus_fetch <= req_fetch;
          bus_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          bus_mask  <= pk_mask;
          bus_dout  <= pk_data;
          sz_q      <= req_sz;
          uns_q     <= req_unsigned & ~req_fetch;
          off_q     <= req_addr[OFF_W-1:0];
        end
      end
    end
  end

  assign busy = bus_en;
endmodule

// File: rtl/lsu_bus_master_chk.sv
module lsu_bus_master_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              misalign_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_dout,
  input logic              bus_en,
  input logic              bus_ready,
  input logic              bus_wr,
  input logic [3:0]        bus_mask,
  input logic              bus_fetch
);
  // R1
  a_r1_word_addr: assert property (@(posedge clk) disable iff (rst)
    bus_addr[1:0] == 2'b00);

  // R2
  a_r2_hold_cycle: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_ready) |=> (bus_en && $stable(bus_addr) && $stable(bus_mask)
      && $stable(bus_wr) && $stable(bus_fetch) && $stable(bus_dout)));

  // R3
  a_r3_ready_ends: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_ready) |=> (!bus_en && !bus_wr && done));

  // R3
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  a_r4_wr_in_store: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_en && !bus_fetch));

  // R6
  a_r6_legal_mask: assert property (@(posedge clk) disable iff (rst)
    (bus_mask == 4'b1111) || (bus_mask == 4'b1100) || (bus_mask == 4'b0011)
      || ($countones(bus_mask) == 1));

  // R9
  a_r9_err_no_cycle: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!bus_en && !done));
endmodule

bind lsu_bus_master lsu_bus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .done         (done),
  .misalign_err (misalign_err),
  .bus_addr     (bus_addr),
  .bus_dout     (bus_dout),
  .bus_en       (bus_en),
  .bus_ready    (bus_ready),
  .bus_wr       (bus_wr),
  .bus_mask     (bus_mask),
  .bus_fetch    (bus_fetch)
);

// File: tb/sim_lsu_bus_master.sv
module sim_lsu_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int RAND_CYCLES = 6000;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_fetch, req_write, req_unsigned;
  logic [1:0] req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] req_wdata;
  logic busy, done, misalign_err;
  logic [31:0] rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_din, bus_dout;
  logic bus_en, bus_ready, bus_wr, bus_fetch;
  logic [3:0] bus_mask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_bus_master #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_write(req_write), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .misalign_err(misalign_err), .bus_addr(bus_addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_en(bus_en),
    .bus_ready(bus_ready), .bus_wr(bus_wr), .bus_mask(bus_mask),
    .bus_fetch(bus_fetch)
  );

  // reference model state
  bit        m_en, m_wr, m_fetch, m_done, m_err, m_uns;
  bit [31:0] m_addr, m_dout, m_rdata;
  bit [3:0]  m_mask;
  int        m_kind; // 0 byte, 1 half, 2 word
  int        m_off;

  function automatic bit [31:0] load_value(bit [31:0] w, int kind, int off, bit uns);
    bit [31:0] v;
    if (kind == 0) begin
      v = (w >> (8*off)) & 32'hFF;
      if (!uns && v[7]) v = v | 32'hFFFF_FF00;
    end else if (kind == 1) begin
      v = (w >> (8*off)) & 32'hFFFF;
      if (!uns && v[15]) v = v | 32'hFFFF_0000;
    end else begin
      v = w;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_wr <= 0; m_fetch <= 0; m_done <= 0; m_err <= 0;
      m_addr <= 0; m_dout <= 0; m_rdata <= 0; m_mask <= 4'hF;
    end else begin
      m_done <= 0;
      m_err  <= 0;
      if (m_en) begin
        if (bus_ready) begin
          m_en <= 0; m_wr <= 0; m_done <= 1;
          m_rdata <= load_value(bus_din, m_kind, m_off, m_uns);
        end
      end else if (req_valid) begin
        int kind;
        int off;
        bit bad;
        off  = int'(req_addr[1:0]);
        kind = (req_fetch || req_size >= 2) ? 2 : int'(req_size);
        bad  = (kind == 1 && (off % 2) != 0) || (kind == 2 && off != 0);
        if (bad) m_err <= 1;
        else begin
          m_en    <= 1;
          m_wr    <= req_write && !req_fetch;
          m_fetch <= req_fetch;
          m_addr  <= req_addr & ~32'h3;
          m_kind  <= kind;
          m_off   <= off;
          m_uns   <= req_unsigned && !req_fetch;
          if (kind == 0) begin
            m_mask <= 4'(1 << off);
            m_dout <= (req_wdata & 32'hFF) * 32'h0101_0101;
          end else if (kind == 1) begin
            m_mask <= (off == 0) ? 4'b0011 : 4'b1100;
            m_dout <= (req_wdata & 32'hFFFF) * 32'h0001_0001;
          end else begin
            m_mask <= 4'b1111;
            m_dout <= req_wdata;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(bus_addr == m_addr, "R1 bus_addr", bus_addr, m_addr);
    check(bus_en == m_en, "R2 R11 bus_en", bus_en, m_en);
    check(busy == m_en, "R2 busy", busy, m_en);
    check(done == m_done, "R3 done", done, m_done);
    check(bus_wr == m_wr, "R4 bus_wr", bus_wr, m_wr);
    check(bus_fetch == m_fetch, "R4 bus_fetch", bus_fetch, m_fetch);
    check(bus_mask == m_mask, "R5 bus_mask", bus_mask, m_mask);
    check(bus_mask inside {4'hF, 4'hC, 4'h3, 4'h8, 4'h4, 4'h2, 4'h1},
          "R6 legal mask", bus_mask, 4'hF);
    check(bus_dout == m_dout, "R7 bus_dout", bus_dout, m_dout);
    check(rdata == m_rdata, "R8 rdata", rdata, m_rdata);
    check(misalign_err == m_err, "R9 misalign_err", misalign_err, m_err);
  endtask

  task automatic drive_random();
    req_valid    = ($urandom_range(0, 3) != 0);
    req_fetch    = ($urandom_range(0, 4) == 0);
    req_write    = $urandom_range(0, 1) == 1;
    req_size     = 2'($urandom_range(0, 3));
    req_unsigned = $urandom_range(0, 1) == 1;
    req_addr     = $urandom;
    req_wdata    = $urandom;
    bus_ready    = ($urandom_range(0, 2) == 0);
    bus_din      = $urandom;
  endtask

  task automatic drive_req(bit f, bit w, bit [1:0] s, bit u, bit [31:0] a, bit [31:0] d);
    req_valid = 1; req_fetch = f; req_write = w; req_size = s;
    req_unsigned = u; req_addr = a; req_wdata = d;
  endtask

  initial begin
    bit seen_err;
    rst = 1;
    drive_random();
    req_valid = 1;
    repeat (3) begin
      @(negedge clk);
      // R10: reset state
      check(!bus_en && !bus_wr && !done && !misalign_err && !bus_fetch,
            "R10 reset controls", {bus_en, bus_wr, done, misalign_err, bus_fetch}, 0);
      check(bus_mask == 4'hF && bus_addr == 0 && bus_dout == 0 && rdata == 0,
            "R10 reset data", bus_mask, 4'hF);
      drive_random();
    end
    rst = 0;
    // directed: signed byte load from lane 3, stall two cycles
    drive_req(0, 0, 2'b00, 0, 32'h0000_1003, 0);
    bus_ready = 0; bus_din = 32'h8011_2233;
    @(negedge clk); compare_all();
    check(bus_mask == 4'b1000, "R5 byte lane 3 mask", bus_mask, 4'b1000);
    req_valid = 1; req_addr = 32'h0000_0010;  // ignored while busy (R11)
    @(negedge clk); compare_all();
    check(bus_addr == 32'h1000, "R11 ignored request", bus_addr, 32'h1000);
    bus_ready = 1; req_valid = 0;
    @(negedge clk); compare_all();
    check(done && rdata == 32'hFFFF_FF80, "R8 signed byte", rdata, 32'hFFFF_FF80);
    // directed: misaligned halfword
    drive_req(0, 1, 2'b01, 0, 32'h0000_2001, 32'h1234);
    bus_ready = 0;
    @(negedge clk); compare_all();
    check(misalign_err && !bus_en, "R9 misaligned half", misalign_err, 1);
    // directed: halfword store upper
    drive_req(0, 1, 2'b01, 0, 32'h0000_2002, 32'hABCD_BEEF);
    @(negedge clk); compare_all();
    check(bus_dout == 32'hBEEF_BEEF && bus_mask == 4'b1100 && bus_wr,
          "R7 half store", bus_dout, 32'hBEEF_BEEF);
    req_valid = 0; bus_ready = 1;
    @(negedge clk); compare_all();
    // random traffic
    for (int i = 0; i < RAND_CYCLES; i++) begin
      drive_random();
      @(negedge clk);
      compare_all();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule